// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller with Shadow Registers

This block models a fuse array of 96 words, 32 data bits each. It also contains the controller that burns the fuses and copies the array into shadow registers. Burning a fuse can only move a bit from 0 to 1, so every program operation merges the new value into the old one with a bitwise OR.

The two word ranges behave differently:
- **Words 0 to 31** hold plain data. They accept bits set one at a time over many operations.
- **Words 32 to 95** also hold a 7-bit error-correcting check field. The check field is burned by OR as well. A second program operation with different data can therefore leave the check field inconsistent with the data. The controller does not notice this when programming. It only shows up when the word is next reloaded.

Software reaches the block through a simple request interface with these operations:
- **Read** returns the shadow copy of a word.
- **Program** ORs data into the fuses of a word.
- **Lock** burns a per-word lock fuse. A locked word refuses all later programming.

A separate reload command sweeps the whole array into the shadow registers, one word per clock. During the sweep it decodes the check field of each upper word. It corrects single-bit faults and flags uncorrectable words as invalid.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: An accepted request (reqValid and reqReady high at a clock edge) produces rspValid high for exactly the following cycle. For a successful read, rspData and rspStatus in that cycle hold the shadow data and status of the addressed word. For any other response both fields are 0.
- R2: After reset every shadow word reads data 0 and status 0 until the first reload completes.
- R3: A program operation ORs reqData into the word's fuses. A lower word (addresses 0 to 31) reloads as the OR of all data programmed into it, with status bit 0 clear.
- R4: An upper word (addresses 32 to 95) burns a 7-bit check field, ORed with the code of each programmed value. The code is defined as follows:
  - Codeword positions run from 1 to 38.
  - Check bit k (k = 0 to 5) sits at position 2^k.
  - Data bits fill the remaining positions in ascending order, so data bit 0 sits at position 3.
  - Check bit k is the XOR of the data bits whose position has bit k set.
  - Check bit 6 is the XOR of all 32 data bits and check bits 0 to 5.

  An upper word whose stored data and check field form a valid codeword reloads with that data and status bit 0 clear.
- R5: An upper word whose stored data and check field differ from every valid codeword in two or more bits reloads as data 0x00000000 with status bit 0 set.
- R6: An upper word whose stored data and check field are one bit away from a valid codeword reloads with the corrected data and status bit 0 clear.
- R7: A program operation to an in-range, unlocked word always responds with rspErr 0. This holds even when the result leaves an upper word inconsistent.
- R8: A lock operation (reqOp 2) burns a lock fuse that cannot be cleared.
  - A later program operation (reqOp 1) to that word responds with rspErr 1 and leaves its fuses unchanged.
  - After reload, status bit 1 of a locked word is set.
- R9: The following all respond with rspErr 1 and change nothing:
  - a read (reqOp 0), program or lock to an address of 96 or above;
  - any request with reqOp 3.
- R10: A reload command accepted while idle holds reloadBusy high for 96 cycles, loading words 0 to 95 in ascending order. It then pulses reloadDone for one cycle. reqReady is low while reloadBusy or reloadStart is high.
- R11: Program operations do not change the shadow registers. A read after a program and before the next reload returns the previous shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; blanks the fuse model and shadow registers |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 read, 1 program, 2 lock, 3 unsupported |
| reqAddr | input | 7 | Word address |
| reqData | input | 32 | Program data |
| reqReady | output | 1 | Request can be accepted this cycle |
| rspValid | output | 1 | Response present (one cycle after acceptance) |
| rspErr | output | 1 | Request rejected |
| rspData | output | 32 | Shadow data for a read |
| rspStatus | output | 2 | Bit 0 invalid, bit 1 locked |
| reloadStart | input | 1 | Start a reload sweep |
| reloadBusy | output | 1 | Sweep in progress |
| reloadDone | output | 1 | One-cycle pulse at sweep end |

## Verification
Upper words are driven with four input patterns:
- a single write, which must reload clean;
- the same value written twice, where OR is idempotent and the word stays valid;
- two disjoint values whose check codes share exactly one bit, which tests single-error correction;
- two values whose check codes share two bits, which tests the invalid flag.

The same two-value pattern applied to a lower word must reload as a plain OR. This separates the redundant range from the coded range and locates the boundary at words 31 and 32.

Locked words, out-of-range addresses and reads issued between a program and a reload show whether a rejected request or an unreloaded program can leak into the fuses or the shadow copy.

// File: rtl/otp_shadow_pkg.sv
package otp_shadow_pkg;

  localparam int DATA_W    = 32;
  localparam int HAM_W     = 6;
  localparam int CHK_W     = HAM_W + 1;
  localparam int CODE_POS  = DATA_W + HAM_W;   // highest codeword position
  localparam int ADDR_W    = 7;
  localparam int NUM_WORDS = 96;
  localparam int NUM_LOWER = 32;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_LOCK = 2'd2,
    OP_NONE = 2'd3
  } otpOp_e;

  typedef struct packed {
    logic              fuseProg;
    logic              lockProg;
    logic              rdCapture;
    logic              shadowLoad;
    logic [ADDR_W-1:0] loadIdx;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              invalid;
    logic [DATA_W-1:0] data;
  } eccResult_t;

  function automatic logic isPow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int j;
    h = '0;
    j = 0;
    for (int p = 1; p <= CODE_POS; p++) begin
      if (!isPow2(p)) begin
        for (int k = 0; k < HAM_W; k++) begin
          if (p[k]) h[k] = h[k] ^ d[j];
        end
        j++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  function automatic eccResult_t eccDecode(input logic [DATA_W-1:0] d,
                                           input logic [CHK_W-1:0]  c);
    eccResult_t r;
    logic [CHK_W-1:0] re;
    logic [HAM_W-1:0] syn;
    logic par;
    int j;
    re  = eccEncode(d);
    syn = re[HAM_W-1:0] ^ c[HAM_W-1:0];
    par = (^d) ^ (^c);
    r.data    = d;
    r.invalid = 1'b0;
    if (!par) begin
      r.invalid = (syn != '0);
    end else if (syn != '0 && !isPow2(int'(syn))) begin
      if (int'(syn) > CODE_POS) begin
        r.invalid = 1'b1;
      end else begin
        j = 0;
        for (int p = 1; p <= CODE_POS; p++) begin
          if (!isPow2(p)) begin
            if (p == int'(syn)) r.data[j] = ~d[j];
            j++;
          end
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/otp_ctrl_fsm.sv
module otp_ctrl_fsm
  import otp_shadow_pkg::*;
#(
  parameter int NumWords = NUM_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic              reloadStart,
  input  logic              addrOk,
  input  logic              addrLocked,
  output logic              reqReady,
  output ctrlStrobe_t       strb,
  output logic              rspValid,
  output logic              rspErr,
  output logic              reloadBusy,
  output logic              reloadDone
);

  localparam logic [ADDR_W-1:0] LastIdx = ADDR_W'(NumWords - 1);

  logic              busy;
  logic [ADDR_W-1:0] idx;
  logic              accept;
  logic              reqBad;
  otpOp_e            op;

  assign op       = otpOp_e'(reqOp);
  assign reqReady = !busy && !reloadStart;
  assign accept   = reqValid && reqReady;

  always_comb begin
    unique case (op)
      OP_READ: reqBad = !addrOk;
      OP_PROG: reqBad = !addrOk || addrLocked;
      OP_LOCK: reqBad = !addrOk;
      default: reqBad = 1'b1;
    endcase
  end

  always_comb begin
    strb.fuseProg   = accept && !reqBad && (op == OP_PROG);
    strb.lockProg   = accept && !reqBad && (op == OP_LOCK);
    strb.rdCapture  = accept && !reqBad && (op == OP_READ);
    strb.shadowLoad = busy;
    strb.loadIdx    = idx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspErr     <= 1'b0;
      busy       <= 1'b0;
      idx        <= '0;
      reloadDone <= 1'b0;
    end else begin
      rspValid   <= accept;
      rspErr     <= accept && reqBad;
      reloadDone <= 1'b0;
      if (!busy) begin
        if (reloadStart) begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end else if (idx == LastIdx) begin
        busy       <= 1'b0;
        reloadDone <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign reloadBusy = busy;

endmodule

// File: rtl/otp_fuse_datapath.sv
module otp_fuse_datapath
  import otp_shadow_pkg::*;
#(
  parameter int NumWords   = NUM_WORDS,
  parameter int LowerWords = NUM_LOWER
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              addrOk,
  output logic              addrLocked,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspStatus
);

  localparam int UpperWords = NumWords - LowerWords;
  localparam logic [ADDR_W-1:0] LowBase = ADDR_W'(LowerWords);
  localparam logic [ADDR_W-1:0] Span    = ADDR_W'(NumWords);

  logic [DATA_W-1:0] fuseData [NumWords];
  logic [CHK_W-1:0]  fuseChk  [UpperWords];
  logic [NumWords-1:0] lockFuse;
  logic [DATA_W-1:0] shData [NumWords];
  logic [1:0]        shStat [NumWords];

  logic              reqUpper;
  logic [ADDR_W-1:0] reqChkIdx;
  logic [ADDR_W-1:0] safeAddr;
  logic              loadUpper;
  logic [ADDR_W-1:0] loadChkIdx;
  eccResult_t        dec;

  assign addrOk     = reqAddr < Span;
  assign safeAddr   = addrOk ? reqAddr : '0;
  assign addrLocked = addrOk && lockFuse[safeAddr];
  assign reqUpper   = safeAddr >= LowBase;
  assign reqChkIdx  = reqUpper ? safeAddr - LowBase : '0;
  assign loadUpper  = strb.loadIdx >= LowBase;
  assign loadChkIdx = loadUpper ? strb.loadIdx - LowBase : '0;

  // one shared decoder serves the sweep, indexed by the load counter
  assign dec = eccDecode(fuseData[strb.loadIdx], fuseChk[loadChkIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumWords; i++) fuseData[i] <= '0;
      for (int i = 0; i < UpperWords; i++) fuseChk[i] <= '0;
      lockFuse <= '0;
    end else begin
      if (strb.fuseProg) begin
        fuseData[safeAddr] <= fuseData[safeAddr] | reqData;
        if (reqUpper) fuseChk[reqChkIdx] <= fuseChk[reqChkIdx] | eccEncode(reqData);
      end
      if (strb.lockProg) lockFuse[safeAddr] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumWords; i++) begin
        shData[i] <= '0;
        shStat[i] <= '0;
      end
    end else if (strb.shadowLoad) begin
      if (loadUpper) begin
        shData[strb.loadIdx] <= dec.invalid ? '0 : dec.data;
        shStat[strb.loadIdx] <= {lockFuse[strb.loadIdx], dec.invalid};
      end else begin
        shData[strb.loadIdx] <= fuseData[strb.loadIdx];
        shStat[strb.loadIdx] <= {lockFuse[strb.loadIdx], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData   <= '0;
      rspStatus <= '0;
    end else begin
      rspData   <= strb.rdCapture ? shData[safeAddr] : '0;
      rspStatus <= strb.rdCapture ? shStat[safeAddr] : '0;
    end
  end

endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
  import otp_shadow_pkg::*;
#(
  parameter int NumWords   = NUM_WORDS,
  parameter int LowerWords = NUM_LOWER
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspStatus,
  input  logic              reloadStart,
  output logic              reloadBusy,
  output logic              reloadDone
);

  ctrlStrobe_t strb;
  logic        addrOk;
  logic        addrLocked;

  otp_ctrl_fsm #(.NumWords(NumWords)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reloadStart(reloadStart),
    .addrOk     (addrOk),
    .addrLocked (addrLocked),
    .reqReady   (reqReady),
    .strb       (strb),
    .rspValid   (rspValid),
    .rspErr     (rspErr),
    .reloadBusy (reloadBusy),
    .reloadDone (reloadDone)
  );

  otp_fuse_datapath #(.NumWords(NumWords), .LowerWords(LowerWords)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .addrOk    (addrOk),
    .addrLocked(addrLocked),
    .rspData   (rspData),
    .rspStatus (rspStatus)
  );

endmodule

// File: rtl/otp_shadow_chk.sv
module otp_shadow_chk
  import otp_shadow_pkg::*;
#(
  parameter int NumWords = NUM_WORDS
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspErr,
  input logic [DATA_W-1:0] rspData,
  input logic [1:0]        rspStatus,
  input logic              reloadBusy,
  input logic              reloadDone
);

  logic [ADDR_W+1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (reloadBusy) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  p_rsp_follows_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

  p_range_error_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (int'(reqAddr) >= NumWords)) |=> (rspValid && rspErr));

  p_invalid_reads_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus[0]) |-> (rspData == '0));

  p_error_no_payload_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspData == '0 && rspStatus == '0));

  p_ready_low_in_sweep_r10: assert property (@(posedge clk) disable iff (!rstN)
    reloadBusy |-> !reqReady);

  p_done_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    reloadDone |=> !reloadDone);

  p_sweep_length_r10: assert property (@(posedge clk) disable iff (!rstN)
    reloadDone |-> (int'(busyCnt) == NumWords));

endmodule

bind otp_shadow_ctrl otp_shadow_chk #(.NumWords(NumWords)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .rspValid  (rspValid),
  .rspErr    (rspErr),
  .rspData   (rspData),
  .rspStatus (rspStatus),
  .reloadBusy(reloadBusy),
  .reloadDone(reloadDone)
);

// File: tb/sim_otp_shadow_ctrl.sv
`timescale 1ns/1ps
module sim_otp_shadow_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [6:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        reqReady;
  logic        rspValid;
  logic        rspErr;
  logic [31:0] rspData;
  logic [1:0]  rspStatus;
  logic        reloadStart = 1'b0;
  logic        reloadBusy;
  logic        reloadDone;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  otp_shadow_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .rspStatus(rspStatus), .reloadStart(reloadStart),
    .reloadBusy(reloadBusy), .reloadDone(reloadDone)
  );

  // ---------------- behavioural reference ----------------
  function automatic int posOfData(input int j);
    int p = 0;
    int seen = -1;
    while (seen < j) begin
      p++;
      if ((p & (p - 1)) != 0) seen++;
    end
    return p;
  endfunction

  function automatic logic [6:0] refCode(input logic [31:0] d);
    logic [6:0] c = '0;
    int ones = 0;
    for (int j = 0; j < 32; j++) begin
      if (d[j]) begin
        int p = posOfData(j);
        ones++;
        for (int k = 0; k < 6; k++) if ((p >> k) & 1) c[k] = ~c[k];
      end
    end
    for (int k = 0; k < 6; k++) if (c[k]) ones++;
    c[6] = ones[0];
    return c;
  endfunction

  // brute-force decode: exact codeword, else search single flips
  task automatic refDecode(input logic [31:0] d, input logic [6:0] c,
                           output logic [31:0] od, output logic bad);
    logic [38:0] w = {c, d};
    od = 32'h0;
    bad = 1'b1;
    if (refCode(d) == c) begin
      od = d;
      bad = 1'b0;
    end else begin
      for (int b = 0; b < 39; b++) begin
        logic [38:0] t = w ^ (39'd1 << b);
        if (bad && refCode(t[31:0]) == t[38:32]) begin
          od = t[31:0];
          bad = 1'b0;
        end
      end
    end
  endtask

  logic [31:0] mFd [96];
  logic [6:0]  mFc [96];
  logic [95:0] mLock;
  logic [31:0] mSh [96];
  logic [1:0]  mSt [96];
  logic        mBusy, mDone, mRspV, mRspE;
  int          mIdx;
  logic [31:0] mRspD;
  logic [1:0]  mRspS;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 96; i++) begin
        mFd[i] = 0; mFc[i] = 0; mSh[i] = 0; mSt[i] = 0;
      end
      mLock = 0; mBusy = 0; mDone = 0; mIdx = 0;
      mRspV = 0; mRspE = 0; mRspD = 0; mRspS = 0;
    end else begin
      logic acc, bad, inR;
      int a;
      acc = reqValid && !mBusy && !reloadStart;
      a = int'(reqAddr);
      inR = a < 96;
      bad = !inR || reqOp == 2'd3 || (reqOp == 2'd1 && mLock[a]);
      mRspV = acc;
      mRspE = acc && bad;
      mRspD = 0; mRspS = 0;
      if (acc && !bad) begin
        if (reqOp == 2'd0) begin
          mRspD = mSh[a]; mRspS = mSt[a];
        end else if (reqOp == 2'd1) begin
          mFd[a] = mFd[a] | reqData;
          if (a >= 32) mFc[a] = mFc[a] | refCode(reqData);
        end else begin
          mLock[a] = 1'b1;
        end
      end
      mDone = 0;
      if (mBusy) begin
        logic [31:0] od;
        logic ib;
        if (mIdx >= 32) refDecode(mFd[mIdx], mFc[mIdx], od, ib);
        else begin od = mFd[mIdx]; ib = 0; end
        mSh[mIdx] = ib ? 32'h0 : od;
        mSt[mIdx] = {mLock[mIdx], ib};
        if (mIdx == 95) begin mBusy = 0; mDone = 1; end
        else mIdx++;
      end else if (reloadStart) begin
        mBusy = 1; mIdx = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the reference on every cycle
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      check(rspValid == mRspV, "R1 rspValid", 32'(rspValid), 32'(mRspV));
      check(rspErr == mRspE, "R9 rspErr", 32'(rspErr), 32'(mRspE));
      check(rspData == mRspD, "R4 rspData", rspData, mRspD);
      check(rspStatus == mRspS, "R5 rspStatus", 32'(rspStatus), 32'(mRspS));
      check(reloadBusy == mBusy, "R10 busy", 32'(reloadBusy), 32'(mBusy));
      check(reloadDone == mDone, "R10 done", 32'(reloadDone), 32'(mDone));
      check(reqReady == (!mBusy && !reloadStart), "R10 ready",
            32'(reqReady), 32'(!mBusy && !reloadStart));
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReq(input logic [1:0] op, input int a, input logic [31:0] d,
                       output logic e, output logic [31:0] rd, output logic [1:0] rs);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = 7'(a); reqData = d;
    @(negedge clk);
    #1;
    check(rspValid == 1'b1, "R1 latency", 32'(rspValid), 32'd1);
    e = rspErr; rd = rspData; rs = rspStatus;
    reqValid = 1'b0;
  endtask

  task automatic prog(input int a, input logic [31:0] d, input logic expErr, input string tag);
    logic e; logic [31:0] rd; logic [1:0] rs;
    doReq(2'd1, a, d, e, rd, rs);
    check(e == expErr, tag, 32'(e), 32'(expErr));
  endtask

  task automatic readExp(input int a, input logic [31:0] ed, input logic [1:0] es,
                         input string tag);
    logic e; logic [31:0] rd; logic [1:0] rs;
    doReq(2'd0, a, 32'h0, e, rd, rs);
    check(e == 1'b0, tag, 32'(e), 32'd0);
    check(rd == ed, tag, rd, ed);
    check(rs == es, tag, 32'(rs), 32'(es));
  endtask

  task automatic doReload();
    int n = 0;
    @(negedge clk);
    reloadStart = 1'b1;
    #1;
    check(reqReady == 1'b0, "R10 ready during start", 32'(reqReady), 32'd0);
    @(negedge clk);
    reloadStart = 1'b0;
    #1;
    while (!reloadDone && n < 500) begin
      if (reloadBusy) n++;
      @(negedge clk);
      #1;
    end
    check(n == 96, "R10 sweep length", 32'(n), 32'd96);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    finish();
  end

  initial begin
    logic e; logic [31:0] rd; logic [1:0] rs;
    repeat (4) @(negedge clk);
    check(rspValid == 0 && reloadBusy == 0 && reloadDone == 0, "R2 reset outputs",
          {29'd0, rspValid, reloadBusy, reloadDone}, 32'd0);
    rstN = 1'b1;

    readExp(5, 32'h0, 2'b00, "R2 blank shadow");
    readExp(93, 32'h0, 2'b00, "R2 blank shadow upper");

    prog(3, 32'h0000_00F0, 1'b0, "R7 lower program ack");
    prog(3, 32'h0000_0100, 1'b0, "R7 lower program ack");
    prog(31, 32'h1, 1'b0, "R7 program ack");
    prog(31, 32'h2, 1'b0, "R7 program ack");
    prog(32, 32'h1, 1'b0, "R7 program ack");
    prog(32, 32'h2, 1'b0, "R7 ack despite corruption");
    prog(40, 32'hDEAD_BEEF, 1'b0, "R7 program ack");
    prog(41, 32'h1, 1'b0, "R7 program ack");
    prog(41, 32'h2, 1'b0, "R7 ack despite corruption");
    prog(42, 32'h1, 1'b0, "R7 program ack");
    prog(42, 32'h100, 1'b0, "R7 program ack");
    prog(43, 32'hA5, 1'b0, "R7 program ack");
    prog(43, 32'hA5, 1'b0, "R7 program ack");
    prog(95, 32'h8000_0000, 1'b0, "R7 program ack");
    prog(44, 32'h55, 1'b0, "R7 program ack");
    doReq(2'd2, 44, 32'h0, e, rd, rs);
    check(e == 1'b0, "R8 lock ack", 32'(e), 32'd0);
    prog(44, 32'hAA, 1'b1, "R8 locked program rejected");
    prog(10, 32'h1, 1'b0, "R7 program ack");
    doReq(2'd2, 10, 32'h0, e, rd, rs);
    check(e == 1'b0, "R8 lock ack lower", 32'(e), 32'd0);
    prog(10, 32'h2, 1'b1, "R8 locked lower rejected");

    doReq(2'd0, 100, 32'h0, e, rd, rs);
    check(e == 1'b1, "R9 read out of range", 32'(e), 32'd1);
    doReq(2'd1, 96, 32'hFFFF_FFFF, e, rd, rs);
    check(e == 1'b1, "R9 program out of range", 32'(e), 32'd1);
    doReq(2'd2, 127, 32'h0, e, rd, rs);
    check(e == 1'b1, "R9 lock out of range", 32'(e), 32'd1);
    doReq(2'd3, 5, 32'hFFFF_FFFF, e, rd, rs);
    check(e == 1'b1, "R9 unsupported op", 32'(e), 32'd1);

    readExp(3, 32'h0, 2'b00, "R11 shadow unchanged before reload");

    doReload();

    readExp(3, 32'h0000_01F0, 2'b00, "R3 lower OR accumulate");
    readExp(31, 32'h3, 2'b00, "R3 lower boundary word");
    readExp(32, 32'h0, 2'b01, "R5 upper boundary invalid");
    readExp(40, 32'hDEAD_BEEF, 2'b00, "R4 single write valid");
    readExp(41, 32'h0, 2'b01, "R5 double error invalid");
    readExp(42, 32'h0000_0101, 2'b00, "R6 single error corrected");
    readExp(43, 32'hA5, 2'b00, "R4 repeated same value valid");
    readExp(95, 32'h8000_0000, 2'b00, "R4 top word valid");
    readExp(44, 32'h55, 2'b10, "R8 locked upper status");
    readExp(10, 32'h1, 2'b10, "R8 locked lower status");
    readExp(5, 32'h0, 2'b00, "R9 op3 left word 5 blank");
    readExp(96 - 96, 32'h0, 2'b00, "R3 word 0 blank");

    prog(3, 32'h0000_000F, 1'b0, "R7 program ack");
    readExp(3, 32'h0000_01F0, 2'b00, "R11 program not visible before reload");
    doReload();
    readExp(3, 32'h0000_01FF, 2'b00, "R3 incremental set");
    readExp(44, 32'h55, 2'b10, "R8 lock persists");

    repeat (3) @(negedge clk);
    finish();
  end

endmodule